// File: doc/BRIEF.md
# Host Mailbox Register Interface

This block is the device-side register file of a byte-wide programmed-I/O message port. A host reaches it through an eight-byte window on an 8-bit I/O bus and uses it to pass messages to and from the device. The window holds a data port, a shared status byte, a control byte, an interrupt acknowledge port and an interrupt routing byte. The status byte carries two message-state fields, one per direction. The host owns the transmit field and the device owns the receive field, so each side can post its handshake step without disturbing the other.

The host raises an event by writing a doorbell bit of the control byte to 0 and then to 1. The block turns every 0-to-1 transition into a one-cycle pulse toward the device. A reset bit in the control byte holds a wake request toward the device. When the host clears that bit after holding it long enough, the block gives a standby-exit pulse. Whenever the device posts a new receive state, an interrupt goes pending. It is driven onto one of eight request lines, chosen by the routing byte and gated by an enable bit, until the host reads the acknowledge port.

Top module: `mbox_host_regs`

## Requirements
- R1: After reset every stored field is 0. Status, control and routing read 0x00, all request lines are low, and `h2d_valid`, `rx_ready`, `wake_req`, `bus16` and the doorbell pulses are 0.
- R2: Byte offsets are decoded as data 0, status 2, control 4, acknowledge 5 and routing 6. Reads of offsets 1, 3, 5 and 7 return 0x00. Writes to offsets 1, 3 and 7 change no readable register.
- R3: A host write to offset 0 puts the byte on `h2d_data` and raises `h2d_valid` for exactly the one cycle after the write. A read of offset 0 returns `d2h_data`.
- R4: A host write to status stores bit 7 (wake flag) and bits 3:0 (transmit state 2:0 plus the clear-NAK flag in bit 3). Bits 6:4 of the written byte are ignored, and the stored receive field keeps its value.
- R5: A device update (`dev_upd`) stores `dev_state` into status bits 6:4. If a host status write lands in the same cycle, the device value wins bits 6:4 and the host value still lands in bits 7 and 3:0.
- R6: `rx_ready` is 1 exactly when the receive state is 1 (high length available), 5 (error) or 6 (low length available), that is, status values 0x10, 0x50 or 0x60 in bits 6:4.
- R7: Control keeps bits 5:0 and reads bits 7:6 as 0. Bit 5 drives `bus16`.
- R8: A control write that takes bit 0 from 0 to 1 gives a one-cycle `rx_bell` pulse in the cycle after the write. Bit 1 does the same for `tx_bell`. A write that leaves a bit at 1 or clears it gives no pulse.
- R9: `wake_req` is high for exactly as long as control bit 4 is set.
- R10: A control write that clears bit 4 gives a one-cycle `wake_exit` pulse in the cycle after the write, provided bit 4 was set during at least WAKE_MIN_CYC whole cycles before that write. After a shorter hold it gives no pulse.
- R11: Routing bits 2:0 select a request line and bit 4 enables delivery. They read back in place, and all other bits read 0.
- R12: A device update makes the interrupt pending. While it is pending and enabled, only the selected line of `irq_lines` is high. Clearing the enable hides the request but leaves it pending.
- R13: A host read of offset 5 clears the pending interrupt. If a device update falls in the same cycle, the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Byte offset within the window |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the addressed offset (combinational) |
| d2h_data | input | 8 | Byte the device offers on the data port |
| h2d_data | output | 8 | Last byte the host wrote to the data port |
| h2d_valid | output | 1 | One-cycle strobe after a data port write |
| dev_upd | input | 1 | Device posts a new receive state |
| dev_state | input | 3 | Receive state code posted by the device |
| status_byte | output | 8 | Current status byte as seen by the device |
| rx_ready | output | 1 | Receive state needs host service |
| rx_bell | output | 1 | Receive doorbell event pulse |
| tx_bell | output | 1 | Transmit doorbell event pulse |
| bus16 | output | 1 | 16-bit data width selected |
| wake_req | output | 1 | Standby-exit reset request held |
| wake_exit | output | 1 | Pulse when a long enough reset hold is released |
| irq_lines | output | NUM_IRQ | Interrupt request lines, at most one high |

## Verification
The assertions assume the host issues at most one access per cycle, so `host_wr` and `host_rd` are never high together, and that each strobe lasts one cycle. They place no limit on `dev_upd`, which may coincide with any host access, including a status write or an acknowledge read. The bench drives every host access through a task that raises exactly one strobe for one cycle. It makes the device-port collisions deliberately, by raising `dev_upd` in the same cycle as a host access.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd2;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd4;
  localparam logic [OFS_W-1:0] OFS_ACK  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_ROUT = 3'd6;

  // control byte bit positions
  localparam int CB_RX_BELL = 0;
  localparam int CB_TX_BELL = 1;
  localparam int CB_WAKE    = 4;
  localparam int CB_BUS16   = 5;
  localparam int CTRL_W     = 6;

  // routing byte
  localparam int RB_EN = 4;

  typedef enum logic [2:0] {
    MS_IDLE     = 3'd0,
    MS_HI_AVAIL = 3'd1,
    MS_HI_ACC   = 3'd2,
    MS_DONE     = 3'd3,
    MS_XFER     = 3'd4,
    MS_ERR      = 3'd5,
    MS_LO_AVAIL = 3'd6,
    MS_LO_ACC   = 3'd7
  } msg_state_e;

  typedef struct packed {
    logic data_wr;
    logic stat_wr;
    logic ctrl_wr;
    logic rout_wr;
    logic ack_rd;
  } reg_hit_t;

  function automatic logic rx_needs_service(input logic [2:0] st);
    return (st == MS_HI_AVAIL) || (st == MS_ERR) || (st == MS_LO_AVAIL);
  endfunction

  function automatic logic rising_bit(input logic old_v, input logic new_v);
    return new_v & ~old_v;
  endfunction

endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec
  import mbox_pkg::*;
(
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [OFS_W-1:0] host_addr,
  output reg_hit_t         hits
);

  always_comb begin
    hits         = '0;
    hits.data_wr = host_wr && (host_addr == OFS_DATA);
    hits.stat_wr = host_wr && (host_addr == OFS_STAT);
    hits.ctrl_wr = host_wr && (host_addr == OFS_CTRL);
    hits.rout_wr = host_wr && (host_addr == OFS_ROUT);
    hits.ack_rd  = host_rd && (host_addr == OFS_ACK);
  end

endmodule

// File: rtl/mbox_status_reg.sv
module mbox_status_reg
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_wake,
  input  logic [3:0]        host_low,
  input  logic              dev_upd,
  input  logic [2:0]        dev_state,
  output logic [BYTE_W-1:0] status_byte,
  output logic              rx_ready
);

  logic       wake_q;
  logic [3:0] host_q;
  logic [2:0] dev_q;

  // host-owned part: wake flag and transmit field
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      host_q <= '0;
    end else if (host_wr) begin
      wake_q <= host_wake;
      host_q <= host_low;
    end
  end

  // device-owned receive field; the host path never reaches it
  always_ff @(posedge clk) begin
    if (!rst_n) dev_q <= '0;
    else if (dev_upd) dev_q <= dev_state;
  end

  assign status_byte = {wake_q, dev_q, host_q};
  assign rx_ready    = rx_needs_service(dev_q);

  a_r4_host_keeps_rx_field: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !dev_upd) |=> $stable(dev_q));

  a_r5_device_wins_rx_field: assert property (@(posedge clk) disable iff (!rst_n)
    dev_upd |=> (status_byte[6:4] == $past(dev_state)));

  a_r5_host_low_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && dev_upd) |=> (status_byte[3:0] == $past(host_low)));

endmodule

// File: rtl/mbox_ctrl_bells.sv
module mbox_ctrl_bells
  import mbox_pkg::*;
#(
  parameter int WAKE_MIN_CYC = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic              rx_bell,
  output logic              tx_bell,
  output logic              bus16,
  output logic              wake_req,
  output logic              wake_exit
);

  localparam int CNT_W = $clog2(WAKE_MIN_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_MAX = CNT_W'(WAKE_MIN_CYC);
  localparam int NBELL = 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NBELL-1:0]  bell_q;
  logic [CNT_W-1:0]  hold_cnt;
  logic              exit_q;
  logic              wake_release;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_wdata;
  end

  // one pulse generator per doorbell bit (bits 0 and 1)
  for (genvar b = 0; b < NBELL; b++) begin : g_bell
    always_ff @(posedge clk) begin
      if (!rst_n) bell_q[b] <= 1'b0;
      else bell_q[b] <= ctrl_wr && rising_bit(ctrl_q[b], ctrl_wdata[b]);
    end

    a_r8_bell_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      bell_q[b] |=> !bell_q[b]);
  end

  // saturating count of cycles the wake bit has been held
  always_ff @(posedge clk) begin
    if (!rst_n) hold_cnt <= '0;
    else if (!ctrl_q[CB_WAKE]) hold_cnt <= '0;
    else if (hold_cnt != HOLD_MAX) hold_cnt <= hold_cnt + 1'b1;
  end

  assign wake_release = ctrl_wr && ctrl_q[CB_WAKE] && !ctrl_wdata[CB_WAKE];

  always_ff @(posedge clk) begin
    if (!rst_n) exit_q <= 1'b0;
    else exit_q <= wake_release && (hold_cnt >= HOLD_MAX);
  end

  assign ctrl_byte = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
  assign rx_bell   = bell_q[CB_RX_BELL];
  assign tx_bell   = bell_q[CB_TX_BELL];
  assign bus16     = ctrl_q[CB_BUS16];
  assign wake_req  = ctrl_q[CB_WAKE];
  assign wake_exit = exit_q;

  a_r10_exit_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
    wake_exit |-> (!wake_req && $past(wake_req)));

  a_r10_exit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_exit |=> !wake_exit);

  a_r9_wake_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (wake_req == $past(ctrl_wdata[CB_WAKE])));

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
#(
  parameter int NUM_IRQ = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rout_wr,
  input  logic [$clog2(NUM_IRQ)-1:0] rout_sel,
  input  logic               rout_en,
  input  logic               dev_upd,
  input  logic               ack_rd,
  output logic [BYTE_W-1:0]  rout_byte,
  output logic [NUM_IRQ-1:0] irq_lines
);

  localparam int SEL_W = $clog2(NUM_IRQ);

  logic [SEL_W-1:0] sel_q;
  logic             en_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (rout_wr) begin
      sel_q <= rout_sel;
      en_q  <= rout_en;
    end
  end

  // a new device event outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (dev_upd) pend_q <= 1'b1;
    else if (ack_rd) pend_q <= 1'b0;
  end

  always_comb begin
    rout_byte            = '0;
    rout_byte[SEL_W-1:0] = sel_q;
    rout_byte[RB_EN]     = en_q;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign irq_lines[g] = en_q && pend_q && (sel_q == SEL_W'(g));
  end

  a_r12_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  a_r12_masked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rout_byte[RB_EN] |-> (irq_lines == '0));

  a_r12_holds_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_rd) |=> pend_q);

  a_r13_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !dev_upd) |=> !pend_q);

  a_r13_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dev_upd |=> pend_q);

endmodule

// File: rtl/mbox_host_regs.sv
module mbox_host_regs
  import mbox_pkg::*;
#(
  parameter int NUM_IRQ      = 8,
  parameter int WAKE_MIN_CYC = 16
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic [7:0]         d2h_data,
  output logic [7:0]         h2d_data,
  output logic               h2d_valid,
  input  logic               dev_upd,
  input  logic [2:0]         dev_state,
  output logic [7:0]         status_byte,
  output logic               rx_ready,
  output logic               rx_bell,
  output logic               tx_bell,
  output logic               bus16,
  output logic               wake_req,
  output logic               wake_exit,
  output logic [NUM_IRQ-1:0] irq_lines
);

  localparam int SEL_W = $clog2(NUM_IRQ);

  reg_hit_t          hits;
  logic [BYTE_W-1:0] ctrl_byte;
  logic [BYTE_W-1:0] rout_byte;
  logic [BYTE_W-1:0] data_q;
  logic              data_vld_q;

  mbox_addr_dec u_dec (
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .hits      (hits)
  );

  mbox_status_reg u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (hits.stat_wr),
    .host_wake   (host_wdata[7]),
    .host_low    (host_wdata[3:0]),
    .dev_upd     (dev_upd),
    .dev_state   (dev_state),
    .status_byte (status_byte),
    .rx_ready    (rx_ready)
  );

  mbox_ctrl_bells #(.WAKE_MIN_CYC(WAKE_MIN_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (hits.ctrl_wr),
    .ctrl_wdata (host_wdata[CTRL_W-1:0]),
    .ctrl_byte  (ctrl_byte),
    .rx_bell    (rx_bell),
    .tx_bell    (tx_bell),
    .bus16      (bus16),
    .wake_req   (wake_req),
    .wake_exit  (wake_exit)
  );

  mbox_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rout_wr   (hits.rout_wr),
    .rout_sel  (host_wdata[SEL_W-1:0]),
    .rout_en   (host_wdata[RB_EN]),
    .dev_upd   (dev_upd),
    .ack_rd    (hits.ack_rd),
    .rout_byte (rout_byte),
    .irq_lines (irq_lines)
  );

  // host-to-device data byte with a one-cycle strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      data_vld_q <= 1'b0;
    end else begin
      data_vld_q <= hits.data_wr;
      if (hits.data_wr) data_q <= host_wdata;
    end
  end

  assign h2d_data  = data_q;
  assign h2d_valid = data_vld_q;

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (host_addr)
        OFS_DATA: host_rdata = d2h_data;
        OFS_STAT: host_rdata = status_byte;
        OFS_CTRL: host_rdata = ctrl_byte;
        OFS_ROUT: host_rdata = rout_byte;
        default:  host_rdata = '0;
      endcase
    end
  end

  a_r2_odd_offsets_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr[0]) |-> (host_rdata == 8'h00));

  a_r3_data_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_DATA) |=> (h2d_valid && h2d_data == $past(host_wdata)));

  a_r7_ctrl_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == OFS_CTRL) |-> (host_rdata[7:6] == 2'b00));

endmodule

// File: tb/mbox_host_regs_tb.sv
`timescale 1ns/1ps
module mbox_host_regs_tb;

  localparam int NIRQ = 8;
  localparam int WMIN = 16;
  localparam int NVEC = 28;

  // {op(1: read-check, 0: write), addr[2:0], wdata[7:0], expect[7:0], req[3:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 8'h00, 8'h00, 4'd1},   // R1 status after reset
    {1'b1, 3'd4, 8'h00, 8'h00, 4'd1},   // R1 control after reset
    {1'b1, 3'd6, 8'h00, 8'h00, 4'd1},   // R1 routing after reset
    {1'b0, 3'd4, 8'hFF, 8'h00, 4'd7},   // R7 write all ones
    {1'b1, 3'd4, 8'h00, 8'h3F, 4'd7},   // R7 only bits 5:0 kept
    {1'b0, 3'd4, 8'hC0, 8'h00, 4'd7},
    {1'b1, 3'd4, 8'h00, 8'h00, 4'd7},
    {1'b0, 3'd2, 8'hFF, 8'h00, 4'd4},   // R4 host status write
    {1'b1, 3'd2, 8'h00, 8'h8F, 4'd4},   // R4 bits 6:4 ignored
    {1'b0, 3'd2, 8'h75, 8'h00, 4'd4},
    {1'b1, 3'd2, 8'h00, 8'h05, 4'd4},
    {1'b0, 3'd6, 8'hFF, 8'h00, 4'd11},  // R11 routing
    {1'b1, 3'd6, 8'h00, 8'h17, 4'd11},
    {1'b0, 3'd6, 8'hEA, 8'h00, 4'd11},
    {1'b1, 3'd6, 8'h00, 8'h02, 4'd11},
    {1'b0, 3'd1, 8'hFF, 8'h00, 4'd2},   // R2 unused offsets
    {1'b0, 3'd3, 8'hFF, 8'h00, 4'd2},
    {1'b0, 3'd7, 8'hFF, 8'h00, 4'd2},
    {1'b1, 3'd1, 8'h00, 8'h00, 4'd2},
    {1'b1, 3'd3, 8'h00, 8'h00, 4'd2},
    {1'b1, 3'd5, 8'h00, 8'h00, 4'd2},
    {1'b1, 3'd7, 8'h00, 8'h00, 4'd2},
    {1'b1, 3'd2, 8'h00, 8'h05, 4'd2},
    {1'b1, 3'd4, 8'h00, 8'h00, 4'd2},
    {1'b1, 3'd0, 8'h00, 8'hA5, 4'd3},   // R3 device byte on offset 0
    {1'b0, 3'd6, 8'h00, 8'h00, 4'd11},
    {1'b0, 3'd2, 8'h00, 8'h00, 4'd4},
    {1'b1, 3'd2, 8'h00, 8'h00, 4'd4}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      host_addr = '0;
  logic            host_wr = 1'b0;
  logic            host_rd = 1'b0;
  logic [7:0]      host_wdata = '0;
  logic [7:0]      host_rdata;
  logic [7:0]      d2h_data = 8'hA5;
  logic [7:0]      h2d_data;
  logic            h2d_valid;
  logic            dev_upd = 1'b0;
  logic [2:0]      dev_state = '0;
  logic [7:0]      status_byte;
  logic            rx_ready, rx_bell, tx_bell, bus16, wake_req, wake_exit;
  logic [NIRQ-1:0] irq_lines;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbox_host_regs #(.NUM_IRQ(NIRQ), .WAKE_MIN_CYC(WMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .d2h_data(d2h_data), .h2d_data(h2d_data), .h2d_valid(h2d_valid),
    .dev_upd(dev_upd), .dev_state(dev_state), .status_byte(status_byte),
    .rx_ready(rx_ready), .rx_bell(rx_bell), .tx_bell(tx_bell), .bus16(bus16),
    .wake_req(wake_req), .wake_exit(wake_exit), .irq_lines(irq_lines)
  );

  function automatic logic exp_ready(input logic [2:0] s);
    case (s)
      3'd1, 3'd5, 3'd6: return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 chk(tag, 32'(host_rdata), 32'(e));
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic dev_post(input logic [2:0] s);
    @(negedge clk);
    dev_upd = 1'b1; dev_state = s;
    @(posedge clk); #1;
    dev_upd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 output state after reset
    @(negedge clk);
    chk("R1 irq_lines", 32'(irq_lines), 0);
    chk("R1 h2d_valid", 32'(h2d_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    chk("R1 wake_req", 32'(wake_req), 0);
    chk("R1 bus16", 32'(bus16), 0);
    chk("R1 bells", 32'({rx_bell, tx_bell}), 0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[i][3:0], i);
      if (VEC[i][23]) rd_chk(VEC[i][22:20], VEC[i][11:4], tag);
      else wr(VEC[i][22:20], VEC[i][19:12]);
    end

    // R3 data strobe lasts one cycle
    wr(3'd0, 8'h3C);
    chk("R3 h2d_valid", 32'(h2d_valid), 1);
    chk("R3 h2d_data", 32'(h2d_data), 32'h3C);
    @(posedge clk); #1;
    chk("R3 h2d_valid drop", 32'(h2d_valid), 0);

    // R5 and R6: every receive state
    for (int s = 0; s < 8; s++) begin
      dev_post(3'(s));
      chk($sformatf("R6 rx_ready state %0d", s), 32'(rx_ready), 32'(exp_ready(3'(s))));
      rd_chk(3'd2, {1'b0, 3'(s), 4'h0}, "R5 device field");
    end
    rd_chk(3'd5, 8'h00, "R13 ack");

    // R5 collision: host status write together with device update
    @(negedge clk);
    host_addr = 3'd2; host_wdata = 8'hF2; host_wr = 1'b1;
    dev_upd = 1'b1; dev_state = 3'd3;
    @(posedge clk); #1;
    host_wr = 1'b0; dev_upd = 1'b0;
    rd_chk(3'd2, 8'hB2, "R5 collision");
    wr(3'd2, 8'h00);
    rd_chk(3'd2, 8'h30, "R4 rx field kept");
    rd_chk(3'd5, 8'h00, "R13 ack");

    // R12 routing, masking and holding
    wr(3'd6, 8'h05);
    dev_post(3'd1);
    chk("R12 masked", 32'(irq_lines), 0);
    wr(3'd6, 8'h15);
    chk("R12 line 5", 32'(irq_lines), 32'h20);
    wr(3'd4, 8'h00);
    chk("R12 held", 32'(irq_lines), 32'h20);
    wr(3'd6, 8'h05);
    chk("R12 disabled", 32'(irq_lines), 0);
    wr(3'd6, 8'h15);
    chk("R12 still pending", 32'(irq_lines), 32'h20);
    rd_chk(3'd5, 8'h00, "R2 ack reads zero");
    chk("R13 cleared", 32'(irq_lines), 0);

    // R13 acknowledge and event in the same cycle
    @(negedge clk);
    host_addr = 3'd5; host_rd = 1'b1; dev_upd = 1'b1; dev_state = 3'd6;
    @(posedge clk); #1;
    host_rd = 1'b0; dev_upd = 1'b0;
    chk("R13 event wins", 32'(irq_lines), 32'h20);
    rd_chk(3'd5, 8'h00, "R13 ack");
    chk("R13 cleared again", 32'(irq_lines), 0);
    wr(3'd6, 8'h10);
    dev_post(3'd0);
    chk("R12 line 0", 32'(irq_lines), 32'h01);
    rd_chk(3'd5, 8'h00, "R13 ack");

    // R8 doorbells
    wr(3'd4, 8'h00);
    chk("R8 no pulse on clear", 32'({rx_bell, tx_bell}), 0);
    wr(3'd4, 8'h01);
    chk("R8 rx pulse", 32'({rx_bell, tx_bell}), 32'b10);
    @(posedge clk); #1;
    chk("R8 rx pulse ends", 32'({rx_bell, tx_bell}), 0);
    wr(3'd4, 8'h01);
    chk("R8 no pulse when held", 32'({rx_bell, tx_bell}), 0);
    wr(3'd4, 8'h03);
    chk("R8 tx pulse only", 32'({rx_bell, tx_bell}), 32'b01);
    wr(3'd4, 8'h00);
    chk("R8 none on fall", 32'({rx_bell, tx_bell}), 0);
    wr(3'd4, 8'h03);
    chk("R8 both", 32'({rx_bell, tx_bell}), 32'b11);

    // R7 width select
    wr(3'd4, 8'h20);
    chk("R7 bus16", 32'(bus16), 1);
    wr(3'd4, 8'h00);
    chk("R7 bus16 off", 32'(bus16), 0);

    // R9 and R10 long hold
    wr(3'd4, 8'h10);
    chk("R9 wake_req set", 32'(wake_req), 1);
    repeat (WMIN) @(posedge clk);
    #1 chk("R9 wake_req held", 32'(wake_req), 1);
    chk("R10 no early exit", 32'(wake_exit), 0);
    wr(3'd4, 8'h00);
    chk("R10 exit pulse", 32'(wake_exit), 1);
    chk("R9 wake_req clear", 32'(wake_req), 0);
    @(posedge clk); #1;
    chk("R10 exit pulse ends", 32'(wake_exit), 0);

    // R10 short hold
    wr(3'd4, 8'h10);
    repeat (WMIN - 1) @(posedge clk);
    wr(3'd4, 8'h00);
    chk("R10 short hold no exit", 32'(wake_exit), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule